// File: doc/BRIEF.md
# Odd-Ratio Clock Divider with Half-Duty Output

This block takes a reference clock and produces a clock whose frequency is the reference divided by a fixed odd integer, while keeping the high and low phases exactly equal. An even ratio gets an even duty cycle from a plain toggle, but an odd ratio cannot: a single rising-edge flop can only move on whole reference periods. The block therefore builds two half-rate square waves that sit a quarter of their own period apart. One moves on rising reference edges and the other on falling reference edges. Their exclusive-OR is the divided clock.

A modulo-N counter runs on rising edges and picks the moment each square wave flips. The rising-edge wave flips when the count is zero. The falling-edge wave flips when the count equals the integer half of N plus one. The ratio is fixed when the block is built. An even ratio, or a ratio below three, stops elaboration. An asynchronous active-high reset clears the counter and both waves, so the output starts low.

Top module: `oddclk_div`

## Requirements
- R1: While reset is high the output is 0. Raising reset between clock edges drives the output to 0 at once, without waiting for a clock edge.
- R2: After reset is released, each output period lasts N reference periods, measured from one output rising edge to the next.
- R3: Each output high phase lasts exactly N half-periods of the reference clock.
- R4: Each output low phase, apart from the first one after reset, lasts exactly N half-periods of the reference clock.
- R5: The output first rises on the first rising reference edge after reset is released. Count reference half-periods from that edge, starting at 0. The output is then high in half-periods 0 to N-1 of every frame of 2N half-periods, and low in the rest of the frame.
- R6: Outside reset, the output rises only on a rising reference edge and falls only on a falling reference edge.
- R7: The output never produces a pulse, high or low, shorter than one reference half-period.
- R8: The block built with N = 3, N = 5 or N = 7 meets the period, duty and alignment rules above for its own N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock to be divided |
| rst | input | 1 | Asynchronous reset, active high |
| clk_out | output | 1 | Divided clock, N reference periods long, 50% duty |

## Verification
The assertions assume a free-running reference clock with a steady, symmetric period. The falling-edge flop samples the counter half a period after the counter changes, and the properties on both edges depend on that. The assertions also assume that reset is never released on a clock edge. The stimulus keeps to both: the clock is a fixed 50 MHz square wave, and reset is asserted and released only at points a few nanoseconds away from either edge. Reset is applied once from time zero and again in the middle of a high phase, so that the asynchronous clear and the restart alignment are both exercised.

// File: rtl/oddclk_pkg.sv
`timescale 1ns/1ps
package oddclk_pkg;

  // Counter width needed to hold 0 .. n-1.
  function automatic int cnt_width(input int n);
    int w;
    w = 1;
    while ((1 << w) < n) w = w + 1;
    return w;
  endfunction

  // Count value at which the falling-edge toggle flips.
  function automatic int mid_count(input int n);
    return (n / 2) + 1;
  endfunction

  // Count value at which the counter wraps.
  function automatic int last_count(input int n);
    return n - 1;
  endfunction

  // Only odd ratios of three or more are legal.
  function automatic bit ratio_legal(input int n);
    return (n >= 3) && ((n % 2) == 1);
  endfunction

endpackage

// File: rtl/oddclk_modn_counter.sv
`timescale 1ns/1ps
module oddclk_modn_counter
  import oddclk_pkg::*;
#(
  parameter int DIV_N = 5,
  parameter int CW    = cnt_width(DIV_N)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] cnt_o,
  output logic          at_zero_o,
  output logic          at_mid_o
);
  localparam logic [CW-1:0] LAST_V = CW'(last_count(DIV_N));
  localparam logic [CW-1:0] MID_V  = CW'(mid_count(DIV_N));

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          wrap;

  assign wrap = (cnt_q == LAST_V);

  always_comb begin
    if (wrap) cnt_d = '0;
    else      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  // The compares come from the register and change only after a rising edge.
  // The falling-edge user samples them half a period later.
  assign at_zero_o = (cnt_q == '0);
  assign at_mid_o  = (cnt_q == MID_V);
  assign cnt_o     = cnt_q;
endmodule

// File: rtl/oddclk_toggle_cell.sv
`timescale 1ns/1ps
module oddclk_toggle_cell #(
  parameter bit ON_FALL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  output logic q_o
);
  logic q;

  generate
    if (ON_FALL) begin : g_fall
      always_ff @(negedge clk or posedge rst) begin
        if (rst)       q <= 1'b0;
        else if (en_i) q <= ~q;
      end
    end else begin : g_rise
      always_ff @(posedge clk or posedge rst) begin
        if (rst)       q <= 1'b0;
        else if (en_i) q <= ~q;
      end
    end
  endgenerate

  assign q_o = q;
endmodule

// File: rtl/oddclk_div.sv
`timescale 1ns/1ps
module oddclk_div
  import oddclk_pkg::*;
#(
  parameter int DIV_N = 5
) (
  input  logic ref_clk,
  input  logic rst,
  output logic clk_out
);
  localparam int CW = cnt_width(DIV_N);

  generate
    if (!ratio_legal(DIV_N)) begin : g_bad_ratio
      $error("oddclk_div: DIV_N must be odd and at least 3");
    end
  endgenerate

  // Internal events are named so that the bound checker can reach them.
  logic [CW-1:0] cnt_q;
  logic          hit_zero;
  logic          hit_mid;
  logic          rise_tgl;
  logic          fall_tgl;

  oddclk_modn_counter #(.DIV_N(DIV_N), .CW(CW)) u_cnt (
    .clk       (ref_clk),
    .rst       (rst),
    .cnt_o     (cnt_q),
    .at_zero_o (hit_zero),
    .at_mid_o  (hit_mid)
  );

  oddclk_toggle_cell #(.ON_FALL(1'b0)) u_tgl_rise (
    .clk  (ref_clk),
    .rst  (rst),
    .en_i (hit_zero),
    .q_o  (rise_tgl)
  );

  oddclk_toggle_cell #(.ON_FALL(1'b1)) u_tgl_fall (
    .clk  (ref_clk),
    .rst  (rst),
    .en_i (hit_mid),
    .q_o  (fall_tgl)
  );

  // The two inputs are a quarter period apart, so only one of them
  // changes at any moment.
  assign clk_out = rise_tgl ^ fall_tgl;
endmodule

// File: rtl/oddclk_div_chk.sv
`timescale 1ns/1ps
module oddclk_div_chk
  import oddclk_pkg::*;
#(
  parameter int DIV_N = 5,
  parameter int CW    = cnt_width(DIV_N)
) (
  input logic          clk,
  input logic          rst,
  input logic [CW-1:0] cnt,
  input logic          rise_q,
  input logic          fall_q,
  input logic          clk_out
);
  localparam logic [CW-1:0] LAST_V = CW'(last_count(DIV_N));
  localparam logic [CW-1:0] MID_V  = CW'(mid_count(DIV_N));

  p_rst_low_r1: assert property (@(posedge clk) rst |-> (clk_out == 1'b0 && cnt == '0));

  p_cnt_step_r2: assert property (@(posedge clk) disable iff (rst)
    (cnt != LAST_V) |=> (cnt == $past(cnt) + 1'b1));

  p_cnt_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (cnt == LAST_V) |=> (cnt == '0));

  p_rise_tgl_r6: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) |=> (rise_q != $past(rise_q)));

  p_rise_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |=> $stable(rise_q));

  p_fall_tgl_r6: assert property (@(negedge clk) disable iff (rst)
    (cnt == MID_V) |=> (fall_q != $past(fall_q)));

  p_fall_hold_r7: assert property (@(negedge clk) disable iff (rst)
    (cnt != MID_V) |=> $stable(fall_q));
endmodule

bind oddclk_div oddclk_div_chk #(.DIV_N(DIV_N)) u_chk (
  .clk     (ref_clk),
  .rst     (rst),
  .cnt     (cnt_q),
  .rise_q  (rise_tgl),
  .fall_q  (fall_tgl),
  .clk_out (clk_out)
);

// File: tb/oddclk_div_tb.sv
`timescale 1ns/1ps
module oddclk_div_tb_top;
  localparam int HALF_NS = 10;            // 50 MHz reference
  localparam int NV [3] = '{5, 3, 7};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] outs;
  int         checks = 0;
  int         errors = 0;
  int         hc = -1;                    // half-periods since first rise
  bit         done = 1'b0;

  always #HALF_NS clk = ~clk;

  oddclk_div #(.DIV_N(5)) dut_i  (.ref_clk(clk), .rst(rst), .clk_out(outs[0]));
  oddclk_div #(.DIV_N(3)) dut3_i (.ref_clk(clk), .rst(rst), .clk_out(outs[1]));
  oddclk_div #(.DIV_N(7)) dut7_i (.ref_clk(clk), .rst(rst), .clk_out(outs[2]));

  function automatic bit exp_level(input int n, input int h);
    if (h < 0) return 1'b0;
    return ((h % (2 * n)) < n);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural half-period model.
  always @(posedge rst) hc = -1;
  always @(posedge clk) if (!rst) hc = hc + 1;
  always @(negedge clk) if (!rst && hc >= 0) hc = hc + 1;

  // Compare with the model 5 ns after every clock edge (R5, R8).
  always @(clk) begin
    #5;
    if (!rst && !done)
      for (int i = 0; i < 3; i++)
        check(outs[i] == exp_level(NV[i], hc),
              (i == 0) ? "R5" : "R8", int'(outs[i]), int'(exp_level(NV[i], hc)));
  end

  // Edge-timing monitors, one per instance.
  for (genvar g = 0; g < 3; g++) begin : g_mon
    longint t_rise, t_fall;
    bit     have_rise = 0, have_fall = 0;

    always @(posedge rst) begin
      have_rise = 0;
      have_fall = 0;
    end

    always @(posedge outs[g]) if (!rst) begin
      check(clk == 1'b1, "R6", int'(clk), 1);
      if (have_fall) begin
        check(($time - t_fall) == NV[g] * HALF_NS, "R4", int'($time - t_fall), NV[g] * HALF_NS);
        check(($time - t_fall) >= HALF_NS, "R7", int'($time - t_fall), HALF_NS);
      end
      if (have_rise)
        check(($time - t_rise) == NV[g] * 2 * HALF_NS, "R2", int'($time - t_rise), NV[g] * 2 * HALF_NS);
      t_rise = $time;
      have_rise = 1;
    end

    always @(negedge outs[g]) if (!rst) begin
      check(clk == 1'b0, "R6", int'(clk), 0);
      if (have_rise) begin
        check(($time - t_rise) == NV[g] * HALF_NS, "R3", int'($time - t_rise), NV[g] * HALF_NS);
        check(($time - t_rise) >= HALF_NS, "R7", int'($time - t_rise), HALF_NS);
      end
      t_fall = $time;
      have_fall = 1;
    end
  end

  initial begin
    #20;
    check(outs == 3'b000, "R1", int'(outs), 0);        // during initial reset
    #15 rst = 1'b0;                                     // t=35, between edges
    @(posedge clk); #5;
    check(outs == 3'b111, "R5", int'(outs), 7);        // first rise after release
    repeat (300) @(posedge clk);
    wait (outs[0] == 1'b1);
    @(posedge clk); #3 rst = 1'b1;                      // mid high phase
    #1 check(outs == 3'b000, "R1", int'(outs), 0);     // async clear
    repeat (4) begin
      @(negedge clk); #2;
      check(outs == 3'b000, "R1", int'(outs), 0);
    end
    @(posedge clk); #7 rst = 1'b0;
    @(posedge clk); #5;
    check(outs == 3'b111, "R5", int'(outs), 7);
    repeat (300) @(posedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule